// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates six interrupt sources for an 8-bit processor core. The sources are two active-low external pins, three timer events and a serial-port event. Each source has its own enable, and a global enable gates all of them. Each source can be given high or low priority, and a single control input can switch the priority scheme off. Each external pin can be set to level sensing, or to falling-edge capture into an internal flag. The timer and serial flags arrive from their own blocks as level inputs.

When a request wins arbitration, the controller raises `irq_req` and holds a fixed vector address until the core takes it. When the core takes it, the controller pulses `ack_clr` for the flags that hardware must clear, and it records the level of the new handler. A `reti` pulse pops the most recent level. While the core sleeps (idle or power-down), no request is offered. The controller instead drives `wake` and, in the wake-on-any mode, `wake_novec`, which tells the core to resume at the next instruction without taking a vector.

The sequencer has three states:
- `ST_SCAN` evaluates pending requests. It moves to `ST_OFFER` when an eligible request exists and `sleep` is low, and latches the winner in the same cycle.
- `ST_OFFER` holds the request and its vector. It moves to `ST_GRANT` when `cpu_take` is high.
- `ST_GRANT` lasts one cycle. It pulses the clear strobe, pushes the nesting level and then returns to `ST_SCAN` without any condition.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source index i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2) gets the vector 0x0003 + 8*i. That gives 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R2: When `glb_en` is 0, no request is offered, whatever the flags and the per-source enables are.
- R3: When `glb_en` is 1, a pending source is offered only if its `src_en` bit (bit i for index i) is 1.
- R4: Among eligible requests, any source whose `prio_hi` bit is 1 beats every low source. Within one level, the lowest index wins.
- R5: When `prio_off` is 1, all `prio_hi` bits are ignored. Every source is then treated as low, and the winner is the lowest eligible index.
- R6: For pin p, `ext_edge_sel[p]` = 1 selects edge mode. In edge mode, a high-to-low transition of `ext_n[p]`, sampled on a clock edge, sets a flag that stays set after the pin returns high, until the flag is served. When the bit is 0, the source is pending exactly while the pin is low.
- R7: In the single `ST_GRANT` cycle, `ack_clr` is one-hot at the served index for timer 0 and timer 1, and for an external source in edge mode. It is all zero for the serial source, for timer 2 and for a level-mode external source. Outside `ST_GRANT` it is zero.
- R8: While a low handler is active, only high requests are offered. While a high handler is active, nothing is offered. When `prio_off` is 1, any active handler blocks all requests.
- R9: A `reti` pulse pops the high level if it is active, and otherwise the low level. Requests that the popped level blocked become eligible again.
- R10: When `wake_any` is 0, `wake` = `sleep` AND (some source is both pending and enabled, with `glb_en` = 1). `wake_novec` is 0.
- R11: When `wake_any` is 1, `wake` and `wake_novec` are both `sleep` AND (any source is pending), with enables ignored.
- R12: While `sleep` is 1, `irq_req` does not rise.
- R13: `irq_req` and `irq_vec` are held stable from `ST_OFFER` until the cycle after `cpu_take` is sampled high. `irq_req` rises one clock edge after an eligible request is seen in `ST_SCAN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | External request pins, active low (bit 0 = external 0) |
| ext_edge_sel | input | 2 | Per-pin sensing: 1 = falling-edge capture, 0 = level |
| t0_ovf | input | 1 | Timer 0 overflow flag (hardware-cleared) |
| t1_ovf | input | 1 | Timer 1 overflow flag (hardware-cleared) |
| ser_evt | input | 1 | Serial-port flag (software-cleared) |
| t2_evt | input | 1 | Timer 2 flag (software-cleared) |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enables, bit i = index i |
| prio_hi | input | 6 | Per-source high-priority bits |
| prio_off | input | 1 | 1 = priority scheme bypassed |
| wake_any | input | 1 | 1 = any pending flag wakes, resuming without a vector |
| sleep | input | 1 | Core is in idle or power-down |
| cpu_take | input | 1 | Core accepts the offered request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 16 | Vector address of the offered request |
| ack_clr | output | 6 | One-cycle clear strobe for hardware-cleared flags |
| wake | output | 1 | Leave the sleep state |
| wake_novec | output | 1 | Resume at the next instruction without vectoring |

## Verification
The bench builds the block with its defaults: six sources, 16-bit vectors, base 3 and stride 8. With six sources there are only 64 pending patterns. That makes a full sweep of every pending pattern against every priority mask possible, 4096 pairs, and a sweep of every enable mask against all flags set. The winner and the vector are computed by arithmetic in the bench. Directed sequences then cover nesting and pop order, the priority bypass, edge capture against level sensing, and both wake modes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC  = 6;
    localparam int IDX_W = $clog2(NSRC);

    localparam int SRC_X0 = 0;
    localparam int SRC_T0 = 1;
    localparam int SRC_X1 = 2;
    localparam int SRC_T1 = 3;
    localparam int SRC_SR = 4;
    localparam int SRC_T2 = 5;

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_n,
    input  logic [N_PIN-1:0] edge_sel,
    input  logic [N_PIN-1:0] clr,
    output logic [N_PIN-1:0] pend
);
    logic [N_PIN-1:0] prev_q;
    logic [N_PIN-1:0] flag_q;

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        logic fall;
        assign fall = prev_q[p] & ~pin_n[p];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[p] <= 1'b1;
                flag_q[p] <= 1'b0;
            end else begin
                prev_q[p] <= pin_n[p];
                if (!edge_sel[p])
                    flag_q[p] <= 1'b0;
                else if (fall)
                    flag_q[p] <= 1'b1;
                else if (clr[p])
                    flag_q[p] <= 1'b0;
            end
        end

        assign pend[p] = edge_sel[p] ? flag_q[p] : ~pin_n[p];

        // R6
        edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[p] && fall) |=> flag_q[p]);
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] hi,
    input  logic         allow_hi,
    input  logic         allow_lo,
    output logic         valid,
    output logic         win_hi,
    output logic [IW-1:0] idx
);
    logic [N-1:0] elig_hi;
    logic [N-1:0] elig_lo;
    logic [N-1:0] cand;

    always_comb begin
        elig_hi = req & hi & {N{allow_hi}};
        elig_lo = req & ~hi & {N{allow_lo}};
        win_hi  = |elig_hi;
        cand    = win_hi ? elig_hi : elig_lo;
        valid   = |cand;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end

    // R4
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[idx]);
    // R4
    win_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && win_hi) |-> hi[idx]);
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_hi,
    input  logic pop,
    output logic allow_hi,
    output logic allow_lo
);
    logic act_lo_q, act_hi_q;
    logic lo_mid, hi_mid;

    always_comb begin
        lo_mid = act_lo_q;
        hi_mid = act_hi_q;
        if (pop) begin
            if (hi_mid) hi_mid = 1'b0;
            else        lo_mid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_lo_q <= 1'b0;
            act_hi_q <= 1'b0;
        end else begin
            act_lo_q <= lo_mid | (push & ~push_hi);
            act_hi_q <= hi_mid | (push & push_hi);
        end
    end

    assign allow_hi = ~act_hi_q;
    assign allow_lo = ~act_hi_q & ~act_lo_q;

    // R8
    no_push_over_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !act_hi_q);
    // R9
    pop_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && act_hi_q) |=> (!act_hi_q && act_lo_q == $past(act_lo_q)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_n,
    input  logic [1:0]       ext_edge_sel,
    input  logic             t0_ovf,
    input  logic             t1_ovf,
    input  logic             ser_evt,
    input  logic             t2_evt,
    input  logic             glb_en,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  prio_hi,
    input  logic             prio_off,
    input  logic             wake_any,
    input  logic             sleep,
    input  logic             cpu_take,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [NSRC-1:0]  ack_clr,
    output logic             wake,
    output logic             wake_novec
);
    seq_state_t        state, nxt;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_hi;
    logic [1:0]        ext_pend;
    logic [NSRC-1:0]   pend, gated, eff_hi, hw_mask;
    logic              allow_hi, allow_lo;
    logic              pick_valid, pick_hi;
    logic [IDX_W-1:0]  pick_idx;
    logic              push;

    irq_edge_det #(.N_PIN(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_n),
        .edge_sel (ext_edge_sel),
        .clr      ({ack_clr[SRC_X1], ack_clr[SRC_X0]}),
        .pend     (ext_pend)
    );

    always_comb begin
        pend            = '0;
        pend[SRC_X0]    = ext_pend[0];
        pend[SRC_T0]    = t0_ovf;
        pend[SRC_X1]    = ext_pend[1];
        pend[SRC_T1]    = t1_ovf;
        pend[SRC_SR]    = ser_evt;
        pend[SRC_T2]    = t2_evt;
        hw_mask         = '0;
        hw_mask[SRC_X0] = ext_edge_sel[0];
        hw_mask[SRC_T0] = 1'b1;
        hw_mask[SRC_X1] = ext_edge_sel[1];
        hw_mask[SRC_T1] = 1'b1;
    end

    assign gated  = pend & src_en & {NSRC{glb_en}};
    assign eff_hi = prio_hi & ~{NSRC{prio_off}};

    irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (gated),
        .hi       (eff_hi),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo),
        .valid    (pick_valid),
        .win_hi   (pick_hi),
        .idx      (pick_idx)
    );

    irq_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_hi  (sel_hi),
        .pop      (reti),
        .allow_hi (allow_hi),
        .allow_lo (allow_lo)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SCAN:  if (pick_valid && !sleep) nxt = ST_OFFER;
            ST_OFFER: if (cpu_take)             nxt = ST_GRANT;
            ST_GRANT:                           nxt = ST_SCAN;
            default:                            nxt = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SCAN;
            sel_idx <= '0;
            sel_hi  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_SCAN && nxt == ST_OFFER) begin
                sel_idx <= pick_idx;
                sel_hi  <= pick_hi;
            end
        end
    end

    always_comb begin
        irq_req = 1'b0;
        push    = 1'b0;
        ack_clr = '0;
        irq_vec = VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STRIDE);
        unique case (state)
            ST_SCAN:  ;
            ST_OFFER: irq_req = 1'b1;
            ST_GRANT: begin
                push    = 1'b1;
                ack_clr = (NSRC'(1) << sel_idx) & hw_mask;
            end
            default:  ;
        endcase
    end

    assign wake       = sleep & (wake_any ? |pend : |gated);
    assign wake_novec = sleep & wake_any & |pend;

    // R13
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpu_take) |=> (irq_req && $stable(irq_vec)));
    // R7
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr));
    // R7
    ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_clr) |-> $past(irq_req && cpu_take));
    // R12
    no_offer_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(sleep));
    // R11
    novec_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_novec |-> wake);
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge_sel = 2'b00;
    logic        t0_ovf = 0, t1_ovf = 0, ser_evt = 0, t2_evt = 0;
    logic        glb_en = 0;
    logic [5:0]  src_en = 0, prio_hi = 0;
    logic        prio_off = 0, wake_any = 0, sleep = 0, cpu_take = 0, reti = 0;
    logic        irq_req, wake, wake_novec;
    logic [15:0] irq_vec;
    logic [5:0]  ack_clr;

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge_sel(ext_edge_sel),
        .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .ser_evt(ser_evt), .t2_evt(t2_evt),
        .glb_en(glb_en), .src_en(src_en), .prio_hi(prio_hi), .prio_off(prio_off),
        .wake_any(wake_any), .sleep(sleep), .cpu_take(cpu_take), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .ack_clr(ack_clr),
        .wake(wake), .wake_novec(wake_novec)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_pend(input logic [5:0] p);
        ext_n[0] = ~p[0];
        t0_ovf   = p[1];
        ext_n[1] = ~p[2];
        t1_ovf   = p[3];
        ser_evt  = p[4];
        t2_evt   = p[5];
    endtask

    function automatic int low_idx(input logic [5:0] m);
        for (int i = 0; i < 6; i++) if (m[i]) return i;
        return 7;
    endfunction

    function automatic int exp_win(input logic [5:0] pat, input logic [5:0] pri);
        if ((pat & pri) != 0) return low_idx(pat & pri);
        return low_idx(pat);
    endfunction

    function automatic logic [15:0] vec_of(input int i);
        return 16'(3 + 8 * i);
    endfunction

    // Pulse take; in the GRANT cycle compare the strobe.
    task automatic take_chk(input string tag, input logic [5:0] exp_ack);
        cpu_take = 1'b1;
        @(negedge clk);
        cpu_take = 1'b0;
        chk(tag, ack_clr, exp_ack);
    endtask

    task automatic pop1;
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        cyc_n(3);
        rst_n = 1'b1;
        cyc_n(1);
        chk("reset irq_req", irq_req, 0);
        chk("reset ack_clr", ack_clr, 0);
        chk("reset wake", wake, 0);

        // R1 R4 R7 R13: full sweep of pending pattern x priority mask, level sensing
        glb_en = 1; src_en = 6'h3F;
        for (int pr = 0; pr < 64; pr++) begin
            for (int pt = 0; pt < 64; pt++) begin
                prio_hi = 6'(pr);
                set_pend(6'(pt));
                cyc_n(2);
                if (pt == 0) begin
                    chk("R2 idle no req", irq_req, 0);
                end else begin
                    int w;
                    w = exp_win(6'(pt), 6'(pr));
                    chk("R4 req", irq_req, 1);
                    chk("R1 R4 vector", irq_vec, vec_of(w));
                    take_chk("R7 sweep ack", (w == 1 || w == 3) ? 6'(1 << w) : 6'h00);
                    set_pend(6'h00);
                    @(negedge clk);
                    pop1();
                end
            end
        end
        prio_hi = 0;

        // R3 R2: enable mask sweep, all flags set
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 64; e++) begin
                glb_en = g[0]; src_en = 6'(e);
                set_pend(6'h3F);
                cyc_n(2);
                if (g == 0 || e == 0) begin
                    chk("R2 R3 blocked", irq_req, 0);
                end else begin
                    chk("R3 vec", irq_vec, vec_of(low_idx(6'(e))));
                    take_chk("R3 ack", 6'h00 | (((low_idx(6'(e)) == 1) || (low_idx(6'(e)) == 3)) ? 6'(1 << low_idx(6'(e))) : 6'h00));
                    set_pend(6'h00);
                    @(negedge clk);
                    pop1();
                end
                set_pend(6'h00);
                cyc_n(1);
            end
        end
        glb_en = 1; src_en = 6'h3F;

        // R8 R9: nesting
        prio_hi = 6'b001010;
        ser_evt = 1; cyc_n(2);
        chk("R8 low offered", irq_vec, 16'h0023);
        take_chk("R7 serial no clr", 6'h00);
        cyc_n(2);
        chk("R8 low blocked under low", irq_req, 0);
        t1_ovf = 1; cyc_n(2);
        chk("R8 high preempts low", irq_vec, 16'h001B);
        take_chk("R7 timer1 clr", 6'b001000);
        t1_ovf = 0; t0_ovf = 1;
        cyc_n(2);
        chk("R8 high blocked under high", irq_req, 0);
        pop1(); cyc_n(2);
        chk("R9 pop high re-opens high", irq_vec, 16'h000B);
        take_chk("R7 timer0 clr", 6'b000010);
        t0_ovf = 0;
        cyc_n(1);
        pop1(); cyc_n(2);
        chk("R9 low still active", irq_req, 0);
        pop1(); cyc_n(2);
        chk("R9 pop low re-opens serial", irq_vec, 16'h0023);
        take_chk("R7 serial again", 6'h00);
        ser_evt = 0; cyc_n(1); pop1();

        // R5: priority bypass
        prio_hi = 6'b010000; prio_off = 1;
        ser_evt = 1; t0_ovf = 1; cyc_n(2);
        chk("R5 order only", irq_vec, 16'h000B);
        take_chk("R5 ack t0", 6'b000010);
        t0_ovf = 0; cyc_n(2);
        chk("R5 R8 no preempt when bypassed", irq_req, 0);
        pop1(); cyc_n(2);
        chk("R5 serial after pop", irq_vec, 16'h0023);
        take_chk("R5 serial ack", 6'h00);
        ser_evt = 0; cyc_n(1); pop1();
        prio_off = 0; prio_hi = 0;

        // R6 R7: edge capture on external 0
        ext_edge_sel = 2'b01;
        cyc_n(1);
        ext_n[0] = 1'b0; cyc_n(1);
        ext_n[0] = 1'b1; cyc_n(2);
        chk("R6 edge flag held", irq_req, 1);
        chk("R6 edge vec", irq_vec, 16'h0003);
        take_chk("R7 edge ext clr", 6'b000001);
        cyc_n(1); pop1(); cyc_n(2);
        chk("R6 flag cleared by service", irq_req, 0);
        // level mode on external 1: no clear, re-offered
        ext_n[1] = 1'b0; cyc_n(2);
        chk("R6 level vec", irq_vec, 16'h0013);
        take_chk("R7 level no clr", 6'h00);
        cyc_n(1); pop1(); cyc_n(2);
        chk("R6 level still pending", irq_req, 1);
        take_chk("R7 level no clr 2", 6'h00);
        ext_n[1] = 1'b1; cyc_n(1); pop1();
        ext_edge_sel = 2'b00;

        // R10 R11 R12: wake
        sleep = 1; src_en = 0; ser_evt = 1; wake_any = 0;
        cyc_n(2);
        chk("R10 disabled no wake", wake, 0);
        wake_any = 1; cyc_n(1);
        chk("R11 any wake", wake, 1);
        chk("R11 novec", wake_novec, 1);
        wake_any = 0; src_en = 6'b010000; cyc_n(1);
        chk("R10 enabled wake", wake, 1);
        chk("R10 novec low", wake_novec, 0);
        glb_en = 0; cyc_n(1);
        chk("R10 global off no wake", wake, 0);
        glb_en = 1; cyc_n(3);
        chk("R12 no req asleep", irq_req, 0);
        sleep = 0; cyc_n(2);
        chk("R12 req after sleep", irq_vec, 16'h0023);
        take_chk("R12 ack", 6'h00);
        ser_evt = 0; cyc_n(1); pop1();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule